// File: doc/BRIEF.md
# Full-Duplex Pause Flow Controller

This block carries both halves of MAC Control pause handling for a full-duplex Ethernet MAC. Carrier sense and collisions play no part in full duplex, so the only brake on the transmitter is a pause request sent by the link partner. The block watches end-of-frame events from the receive parser. When a correct pause frame arrives, it loads a quanta counter and holds the transmitter until the requested time has run out. A quantum is 512 bit times, given here as a whole number of clock cycles.

It also protects the local receive FIFO. When occupancy rises above a high watermark, it asks the transmit path for one pause frame that carries a configured nonzero time. Once occupancy drops below a low watermark, it asks for one pause frame with time zero, which releases the partner. Two enable inputs switch the honouring and generating sides on and off independently. Two status outputs report whether a pause is in force and how many quanta remain. Building the pause frame itself and its CRC belong to the transmit path.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, tx_hold, paused, pause_req and quanta_left are all zero.
- R2: An rx_done strobe is accepted as a pause frame only if all of these hold: rx_ethertype is 16'h8808, rx_opcode is 16'h0001, rx_fcs_ok is 1 and honor_en is 1. On the next clock, quanta_left equals rx_pause_time and paused is 1 exactly when that value is nonzero.
- R3: A strobe that fails any of the conditions in R2 leaves quanta_left unchanged.
- R4: After a load, quanta_left falls by one each QUANTUM_CYC cycles. The first decrement comes QUANTUM_CYC clocks after the load, so a time of N keeps paused high for N*QUANTUM_CYC cycles. paused drops when the count reaches zero.
- R5: A pause frame that arrives while a pause is running replaces the count and restarts the current quantum. A time of zero ends the pause on the next clock.
- R6: tx_hold is high only while paused is high. tx_hold may rise only on a clock at which tx_in_frame is low, so a frame already in progress finishes. tx_hold falls together with paused.
- R7: While honor_en is low, the count is cleared to zero and pause frames are ignored.
- R8: With gen_en high and no pause-on request outstanding, fifo_level greater than thr_high produces a pause_req pulse lasting one cycle, with pause_req_time equal to xoff_time. The block sends no further request while the level stays high.
- R9: After a pause-on request, fifo_level less than thr_low produces one pause_req pulse with pause_req_time zero. A level between the two marks produces no request.
- R10: While gen_en is low, no pause_req is produced and the outstanding state is forgotten. A level above thr_high when gen_en returns therefore produces a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| honor_en | input | 1 | Obey received pause frames |
| gen_en | input | 1 | Generate pause requests from the FIFO level |
| rx_done | input | 1 | End-of-frame strobe from the receive parser |
| rx_ethertype | input | 16 | Type field of the finished frame |
| rx_opcode | input | 16 | MAC Control opcode of the finished frame |
| rx_pause_time | input | 16 | Requested pause time in quanta |
| rx_fcs_ok | input | 1 | Frame check sequence was correct |
| tx_in_frame | input | 1 | Transmitter is sending a frame |
| fifo_level | input | LVL_W | Receive FIFO occupancy |
| thr_high | input | LVL_W | High watermark |
| thr_low | input | LVL_W | Low watermark |
| xoff_time | input | 16 | Pause time to request on a high crossing |
| tx_hold | output | 1 | Do not start a new transmit frame |
| pause_req | output | 1 | One-cycle request to send a pause frame |
| pause_req_time | output | 16 | Time value for the requested frame |
| paused | output | 1 | A received pause is in force |
| quanta_left | output | 16 | Remaining pause quanta |

## Verification
The receive and generate sides run independently, so a correct pause frame can load the counter in the same cycle that the FIFO level crosses the high watermark. The bench provokes this by applying both stimuli on the same clock. It then judges the two results separately: the scoreboard must see exactly one request carrying xoff_time, and quanta_left must show the received value. A second collision comes from reloading the counter a few cycles into a quantum. The expected count after the reload is worked out from a fresh quantum, and it would be one lower if the old prescaler had been kept.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam logic [15:0] ETYPE_MAC_CTRL = 16'h8808;
  localparam logic [15:0] OPC_PAUSE      = 16'h0001;
  typedef logic [15:0] quanta_t;
endpackage

// File: rtl/pfc_frame_check.sv
module pfc_frame_check
  import pfc_pkg::*;
(
  input  logic    honor_en,
  input  logic    rx_done,
  input  logic [15:0] rx_ethertype,
  input  logic [15:0] rx_opcode,
  input  quanta_t rx_pause_time,
  input  logic    rx_fcs_ok,
  output logic    load,
  output quanta_t load_val
);
  logic type_hit;
  logic opc_hit;

  always_comb begin
    type_hit = (rx_ethertype == ETYPE_MAC_CTRL);
    opc_hit  = (rx_opcode == OPC_PAUSE);
    load     = honor_en & rx_done & rx_fcs_ok & type_hit & opc_hit;
    load_val = rx_pause_time;
  end
endmodule

// File: rtl/pfc_quanta_timer.sv
module pfc_quanta_timer
  import pfc_pkg::*;
#(
  parameter int QUANTUM_CYC = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    load,
  input  quanta_t load_val,
  output quanta_t quanta_left,
  output logic    paused,
  output logic    paused_nxt
);
  localparam int PRESC_W = (QUANTUM_CYC > 2) ? $clog2(QUANTUM_CYC) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(QUANTUM_CYC - 1);

  quanta_t            cnt_q, cnt_n;
  logic [PRESC_W-1:0] presc_q, presc_n;

  always_comb begin
    cnt_n   = cnt_q;
    presc_n = presc_q;
    if (!enable) begin
      cnt_n   = '0;
      presc_n = '0;
    end else if (load) begin
      cnt_n   = load_val;
      presc_n = '0;
    end else if (cnt_q != '0) begin
      if (presc_q == PRESC_LAST) begin
        presc_n = '0;
        cnt_n   = cnt_q - 16'd1;
      end else begin
        presc_n = presc_q + 1'b1;
      end
    end else begin
      presc_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else begin
      cnt_q   <= cnt_n;
      presc_q <= presc_n;
    end
  end

  assign quanta_left = cnt_q;
  assign paused      = (cnt_q != '0);
  assign paused_nxt  = (cnt_n != '0);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && load) |=> (quanta_left == $past(load_val))); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load && quanta_left != '0) |=>
      (quanta_left == $past(quanta_left) || quanta_left == $past(quanta_left) - 16'd1)); // R4
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (quanta_left == '0)); // R7
endmodule

// File: rtl/pfc_watermark.sv
module pfc_watermark
  import pfc_pkg::*;
#(
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] thr_high,
  input  logic [LVL_W-1:0] thr_low,
  input  quanta_t          xoff_time,
  output logic             pause_req,
  output quanta_t          pause_req_time
);
  logic    xoff_q, xoff_n;
  logic    req_q, req_n;
  quanta_t time_q, time_n;
  logic    above, below;

  always_comb begin
    above  = (fifo_level > thr_high);
    below  = (fifo_level < thr_low);
    xoff_n = xoff_q;
    req_n  = 1'b0;
    time_n = time_q;
    if (!gen_en) begin
      xoff_n = 1'b0;
    end else if (!xoff_q && above) begin
      xoff_n = 1'b1;
      req_n  = 1'b1;
      time_n = xoff_time;
    end else if (xoff_q && below) begin
      xoff_n = 1'b0;
      req_n  = 1'b1;
      time_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff_q <= 1'b0;
      req_q  <= 1'b0;
      time_q <= '0;
    end else begin
      xoff_q <= xoff_n;
      req_q  <= req_n;
      if (req_n) time_q <= time_n;
    end
  end

  assign pause_req      = req_q;
  assign pause_req_time = time_q;

  AST_ON_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && xoff_q) |-> $past(fifo_level > thr_high)); // R8
  AST_OFF_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !xoff_q) |-> ($past(fifo_level < thr_low) && pause_req_time == '0)); // R9
  AST_GEN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !pause_req); // R10
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int QUANTUM_CYC = 64,
  parameter int LVL_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             honor_en,
  input  logic             gen_en,
  input  logic             rx_done,
  input  logic [15:0]      rx_ethertype,
  input  logic [15:0]      rx_opcode,
  input  logic [15:0]      rx_pause_time,
  input  logic             rx_fcs_ok,
  input  logic             tx_in_frame,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] thr_high,
  input  logic [LVL_W-1:0] thr_low,
  input  logic [15:0]      xoff_time,
  output logic             tx_hold,
  output logic             pause_req,
  output logic [15:0]      pause_req_time,
  output logic             paused,
  output logic [15:0]      quanta_left
);
  logic    ld;
  quanta_t ld_val;
  logic    paused_nxt;
  logic    hold_q, hold_n;

  pfc_frame_check u_check (
    .honor_en      (honor_en),
    .rx_done       (rx_done),
    .rx_ethertype  (rx_ethertype),
    .rx_opcode     (rx_opcode),
    .rx_pause_time (rx_pause_time),
    .rx_fcs_ok     (rx_fcs_ok),
    .load          (ld),
    .load_val      (ld_val)
  );

  pfc_quanta_timer #(.QUANTUM_CYC(QUANTUM_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (honor_en),
    .load        (ld),
    .load_val    (ld_val),
    .quanta_left (quanta_left),
    .paused      (paused),
    .paused_nxt  (paused_nxt)
  );

  pfc_watermark #(.LVL_W(LVL_W)) u_wmark (
    .clk            (clk),
    .rst_n          (rst_n),
    .gen_en         (gen_en),
    .fifo_level     (fifo_level),
    .thr_high       (thr_high),
    .thr_low        (thr_low),
    .xoff_time      (xoff_time),
    .pause_req      (pause_req),
    .pause_req_time (pause_req_time)
  );

  always_comb begin
    hold_n = paused_nxt & (hold_q | ~tx_in_frame);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_n;
  end

  assign tx_hold = hold_q;

  AST_HOLD_NEEDS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold |-> paused); // R6
  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> !$past(tx_in_frame)); // R6
endmodule

// File: tb/pause_flow_ctrl_bench.sv
module pause_flow_ctrl_bench;
  localparam int Q  = 4;
  localparam int LW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic honor_en, gen_en, rx_done, rx_fcs_ok, tx_in_frame;
  logic [15:0] rx_ethertype, rx_opcode, rx_pause_time, xoff_time;
  logic [LW-1:0] fifo_level, thr_high, thr_low;
  logic tx_hold, pause_req, paused;
  logic [15:0] pause_req_time, quanta_left;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  pause_flow_ctrl #(.QUANTUM_CYC(Q), .LVL_W(LW)) u_pause_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .honor_en(honor_en), .gen_en(gen_en),
    .rx_done(rx_done), .rx_ethertype(rx_ethertype), .rx_opcode(rx_opcode),
    .rx_pause_time(rx_pause_time), .rx_fcs_ok(rx_fcs_ok),
    .tx_in_frame(tx_in_frame), .fifo_level(fifo_level),
    .thr_high(thr_high), .thr_low(thr_low), .xoff_time(xoff_time),
    .tx_hold(tx_hold), .pause_req(pause_req), .pause_req_time(pause_req_time),
    .paused(paused), .quanta_left(quanta_left)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] et, input logic [15:0] op,
                       input logic fcs, input logic [15:0] t);
    rx_ethertype = et; rx_opcode = op; rx_fcs_ok = fcs; rx_pause_time = t;
    rx_done = 1'b1;
    step();
    rx_done = 1'b0;
  endtask

  task automatic expect_req(input logic [15:0] t);
    exp_q.push_back(t);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pause_req) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R8/R9/R10: unexpected request actual=%0h expected=none", pause_req_time);
      end else begin
        chk("R8 R9 request value", pause_req_time, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; honor_en = 1'b1; gen_en = 1'b1; rx_done = 1'b0;
    rx_ethertype = '0; rx_opcode = '0; rx_pause_time = '0; rx_fcs_ok = 1'b0;
    tx_in_frame = 1'b0; fifo_level = '0; thr_high = 10'd100; thr_low = 10'd20;
    xoff_time = 16'h1234;
    step(3);
    rst_n = 1'b1;
    step();
    // R1
    chk("R1 tx_hold", tx_hold, 0);
    chk("R1 paused", paused, 0);
    chk("R1 quanta", quanta_left, 0);
    chk("R1 pause_req", pause_req, 0);

    // R2 load, R6 hold at idle, R4 countdown
    frame(16'h8808, 16'h0001, 1'b1, 16'd3);
    chk("R2 quanta", quanta_left, 3);
    chk("R2 paused", paused, 1);
    chk("R6 hold when idle", tx_hold, 1);
    step(3);
    chk("R4 no early decrement", quanta_left, 3);
    step();
    chk("R4 first decrement", quanta_left, 2);
    step(7);
    chk("R4 last quantum", paused, 1);
    step();
    chk("R4 expired", quanta_left, 0);
    chk("R4 paused off", paused, 0);
    chk("R6 hold falls", tx_hold, 0);

    // R3 rejections
    frame(16'h8808, 16'h0001, 1'b0, 16'd9);
    chk("R3 bad fcs", quanta_left, 0);
    frame(16'h8808, 16'h0002, 1'b1, 16'd9);
    chk("R3 wrong opcode", quanta_left, 0);
    frame(16'h0800, 16'h0001, 1'b1, 16'd9);
    chk("R3 wrong type", quanta_left, 0);

    // R5 reload and zero
    frame(16'h8808, 16'h0001, 1'b1, 16'd10);
    step(2);
    frame(16'h8808, 16'h0001, 1'b1, 16'd5);
    chk("R5 reload value", quanta_left, 5);
    step(3);
    chk("R5 quantum restarted", quanta_left, 5);
    step();
    chk("R5 decrement after reload", quanta_left, 4);
    frame(16'h8808, 16'h0001, 1'b1, 16'd0);
    chk("R5 zero ends pause", paused, 0);

    // R6 frame boundary
    tx_in_frame = 1'b1;
    frame(16'h8808, 16'h0001, 1'b1, 16'd20);
    chk("R6 paused mid frame", paused, 1);
    chk("R6 no hold mid frame", tx_hold, 0);
    step();
    chk("R6 still no hold", tx_hold, 0);
    tx_in_frame = 1'b0;
    step();
    chk("R6 hold at boundary", tx_hold, 1);
    tx_in_frame = 1'b1;
    step();
    chk("R6 hold kept", tx_hold, 1);
    tx_in_frame = 1'b0;

    // R7 honour disabled
    honor_en = 1'b0;
    step();
    chk("R7 cleared", quanta_left, 0);
    chk("R7 hold off", tx_hold, 0);
    frame(16'h8808, 16'h0001, 1'b1, 16'd7);
    chk("R7 ignored", quanta_left, 0);
    honor_en = 1'b1;

    // R8 + R2 in the same cycle
    fifo_level = 10'd150;
    expect_req(16'h1234);
    frame(16'h8808, 16'h0001, 1'b1, 16'd4);
    chk("R2 load beside R8 crossing", quanta_left, 4);
    chk("R8 request pulse", pause_req, 1);
    step(3);
    frame(16'h8808, 16'h0001, 1'b1, 16'd0);

    // R9 hysteresis
    fifo_level = 10'd50;
    step(3);
    fifo_level = 10'd10;
    expect_req(16'h0000);
    step(4);

    // R10 generate disabled
    gen_en = 1'b0;
    fifo_level = 10'd200;
    step(4);
    chk("R10 no request", pause_req, 0);
    gen_en = 1'b1;
    expect_req(16'h1234);
    step(2);
    fifo_level = 10'd5;
    expect_req(16'h0000);
    step(3);

    chk("R8 R9 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule